// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor and Arbitration Watcher

This block observes the clock and data lines of a two-wire open-drain serial bus and tells a local master engine what is happening on them. Both lines float high when idle because of pull-ups, and any device may only pull a line low or let it go, so the bus level is the wired-AND of all drivers. The monitor brings both lines into the system clock domain, finds the edges, and reports start conditions (data falls while the clock stays high), stop conditions (data rises while the clock stays high), clock rising edges, and a busy flag that is set by a start and cleared by a stop.

While the local master is sending, whether address bits or data bits after an address match, it tells the monitor the level it wants on the data line and whether it is sending at all. On every clock rising edge seen on the bus, the monitor compares that intent with the observed data level. If the master has released the line but the bus reads low, another master has won and the monitor pulses `arb_lost` so that the engine can stop driving. The engine deasserts `tx_active` during acknowledge bits it does not drive and while it receives. All pins are plain control and status signals; there is no data stream and so no handshake.

Top module: `bus_watch`

## Requirements
- R1: During and after reset, `start_det`, `stop_det`, `scl_rise`, `arb_lost` and `bus_busy` are 0, and both lines are treated as high so that releasing reset on an idle bus raises no event.
- R2: When the clock is high in two consecutive synchronized samples and data goes from 1 to 0 between them, `start_det` is high for exactly one cycle.
- R3: When the clock is high in two consecutive synchronized samples and data goes from 0 to 1 between them, `stop_det` is high for exactly one cycle.
- R4: `bus_busy` becomes 1 in the cycle `start_det` is high and 0 in the cycle `stop_det` is high, and otherwise holds; a repeated start leaves it at 1 and a stop on an idle bus leaves it at 0.
- R5: `scl_rise` is high for one cycle when the synchronized clock goes from 0 to 1.
- R6: `arb_lost` is high for one cycle when a clock rising edge is seen while `tx_active` is 1, `tx_sda` is 1 (line released) and the synchronized data level is 0.
- R7: `arb_lost` stays 0 when `tx_active` is 0 (acknowledge slot or receive), when `tx_sda` is 0, or when the data level read is 1.
- R8: A data change while the clock is low, or in the same sample as a clock change, yields neither `start_det` nor `stop_det`.
- R9: With the default two synchronizer stages, each event output rises on the third rising clock edge after the line change is applied, and `tx_active`/`tx_sda` are taken at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level, asynchronous |
| sda_in | input | 1 | Bus data line level, asynchronous |
| tx_active | input | 1 | Local master is driving the current bit |
| tx_sda | input | 1 | Level the local master intends: 1 = release, 0 = pull low |
| start_det | output | 1 | One-cycle pulse on a start condition |
| stop_det | output | 1 | One-cycle pulse on a stop condition |
| bus_busy | output | 1 | High between a start and the next stop |
| scl_rise | output | 1 | One-cycle pulse on a bus clock rising edge |
| arb_lost | output | 1 | One-cycle pulse when arbitration is lost |

## Verification
A line change applied between clock edges passes two synchronizer flops and then the output register, so every event output and the busy flag are due on the third rising edge after it, while the transmit intent counts at that third edge only. The bench keeps the last four applied line values and the most recent intent values and, at each falling edge, derives all five expected outputs from them, so every cycle of the sweep is compared at exactly the cycle the result is due. The sweep walks every pair of consecutive line states under every intent setting from both an idle and a busy bus, then continues with random toggling.

// File: rtl/bw_pkg.sv
package bw_pkg;

  typedef struct packed {
    logic scl;
    logic sda;
  } bw_lines_t;

  localparam bw_lines_t BW_IDLE = '{scl: 1'b1, sda: 1'b1};

endpackage

// File: rtl/bw_sync.sv
module bw_sync
  import bw_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  bw_lines_t raw,
  output bw_lines_t cur,
  output bw_lines_t prev
);

  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_q;
  logic [DEPTH-1:0] sda_q;

  // Stages 0..STAGES-1 resynchronize; the last stage holds the prior sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= {DEPTH{BW_IDLE.scl}};
      sda_q <= {DEPTH{BW_IDLE.sda}};
    end else begin
      scl_q <= {scl_q[DEPTH-2:0], raw.scl};
      sda_q <= {sda_q[DEPTH-2:0], raw.sda};
    end
  end

  assign cur  = '{scl: scl_q[STAGES-1], sda: sda_q[STAGES-1]};
  assign prev = '{scl: scl_q[STAGES],   sda: sda_q[STAGES]};

endmodule

// File: rtl/bw_cond.sv
module bw_cond
  import bw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bw_lines_t cur,
  input  bw_lines_t prev,
  output logic      rise_now,
  output logic      start_det,
  output logic      stop_det,
  output logic      scl_rise,
  output logic      bus_busy
);

  logic clk_held;
  logic start_c;
  logic stop_c;

  assign clk_held = prev.scl & cur.scl;
  assign start_c  = clk_held & prev.sda & ~cur.sda;
  assign stop_c   = clk_held & ~prev.sda & cur.sda;
  assign rise_now = ~prev.scl & cur.scl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_det <= 1'b0;
      stop_det  <= 1'b0;
      scl_rise  <= 1'b0;
      bus_busy  <= 1'b0;
    end else begin
      start_det <= start_c;
      stop_det  <= stop_c;
      scl_rise  <= rise_now;
      if (start_c)     bus_busy <= 1'b1;
      else if (stop_c) bus_busy <= 1'b0;
    end
  end

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !start_det);

  assert_stop_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !stop_det);

  assert_busy_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> start_det);

  assert_busy_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> stop_det);

endmodule

// File: rtl/bw_arb.sv
module bw_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_now,
  input  logic line_sda,
  input  logic tx_active,
  input  logic tx_sda,
  output logic arb_lost
);

  logic mismatch;

  // Only a released bit read back low means another master won.
  assign mismatch = rise_now & tx_active & tx_sda & ~line_sda;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arb_lost <= 1'b0;
    else        arb_lost <= mismatch;
  end

endmodule

// File: rtl/bus_watch.sv
module bus_watch
  import bw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic tx_active,
  input  logic tx_sda,
  output logic start_det,
  output logic stop_det,
  output logic bus_busy,
  output logic scl_rise,
  output logic arb_lost
);

  bw_lines_t raw_lines;
  bw_lines_t cur_lines;
  bw_lines_t prev_lines;
  logic      rise_now;

  assign raw_lines = '{scl: scl_in, sda: sda_in};

  bw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (raw_lines),
    .cur  (cur_lines),
    .prev (prev_lines)
  );

  bw_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur      (cur_lines),
    .prev     (prev_lines),
    .rise_now (rise_now),
    .start_det(start_det),
    .stop_det (stop_det),
    .scl_rise (scl_rise),
    .bus_busy (bus_busy)
  );

  bw_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_now (rise_now),
    .line_sda (cur_lines.sda),
    .tx_active(tx_active),
    .tx_sda   (tx_sda),
    .arb_lost (arb_lost)
  );

  assert_arb_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> scl_rise);

  assert_arb_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> !arb_lost);

endmodule

// File: tb/tb_bus_watch.sv
module tb_bus_watch;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1, tx_active = 1'b0, tx_sda = 1'b1;
  logic start_det, stop_det, bus_busy, scl_rise, arb_lost;

  int  vecs = 0;
  int  errs = 0;
  bit  done = 1'b0;

  // h_*[k] = line value applied k falling edges ago
  logic h_scl [1:4];
  logic h_sda [1:4];
  logic h_ta1, h_ts1;
  logic m_busy;

  always #4 clk = ~clk;

  bus_watch dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .tx_active(tx_active), .tx_sda(tx_sda),
    .start_det(start_det), .stop_det(stop_det), .bus_busy(bus_busy),
    .scl_rise(scl_rise), .arb_lost(arb_lost)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // R9: outputs at this edge reflect lines applied 3 and 4 edges ago, intent 1 edge ago.
  task automatic step(input logic s, input logic d, input logic ta, input logic ts);
    logic e_start, e_stop, e_rise, e_arb;
    @(negedge clk);
    e_start = h_scl[4] & h_scl[3] & h_sda[4] & ~h_sda[3];
    e_stop  = h_scl[4] & h_scl[3] & ~h_sda[4] & h_sda[3];
    e_rise  = ~h_scl[4] & h_scl[3];
    e_arb   = e_rise & h_ta1 & h_ts1 & ~h_sda[3];
    if (e_start)     m_busy = 1'b1;
    else if (e_stop) m_busy = 1'b0;
    check("R2/R8 start_det", start_det, e_start);
    check("R3/R8 stop_det",  stop_det,  e_stop);
    check("R4 bus_busy",     bus_busy,  m_busy);
    check("R5/R9 scl_rise",  scl_rise,  e_rise);
    check("R6/R7 arb_lost",  arb_lost,  e_arb);
    for (int k = 4; k > 1; k--) begin
      h_scl[k] = h_scl[k-1];
      h_sda[k] = h_sda[k-1];
    end
    h_scl[1] = s; h_sda[1] = d; h_ta1 = ta; h_ts1 = ts;
    scl_in = s; sda_in = d; tx_active = ta; tx_sda = ts;
  endtask

  task automatic hold(input logic s, input logic d, input logic ta,
                      input logic ts, input int n);
    for (int i = 0; i < n; i++) step(s, d, ta, ts);
  endtask

  initial begin
    for (int k = 1; k <= 4; k++) begin h_scl[k] = 1'b1; h_sda[k] = 1'b1; end
    h_ta1 = 1'b0; h_ts1 = 1'b1; m_busy = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 start_det", start_det, 1'b0);
    check("R1 stop_det",  stop_det,  1'b0);
    check("R1 bus_busy",  bus_busy,  1'b0);
    check("R1 scl_rise",  scl_rise,  1'b0);
    check("R1 arb_lost",  arb_lost,  1'b0);
    rst_n = 1'b1;
    hold(1'b1, 1'b1, 1'b0, 1'b1, 6);   // R1: idle after reset, no events

    // Sweep every line transition under every intent, from idle and busy bus.
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < 4; p++)
        for (int c = 0; c < 4; c++)
          for (int t = 0; t < 4; t++) begin
            if (b == 1) begin
              hold(1'b1, 1'b1, 1'b0, 1'b1, 4);
              hold(1'b1, 1'b0, 1'b0, 1'b1, 4);
            end else begin
              hold(1'b0, 1'b0, 1'b0, 1'b1, 4);
              hold(1'b1, 1'b0, 1'b0, 1'b1, 4);
              hold(1'b1, 1'b1, 1'b0, 1'b1, 4);
            end
            hold(p[1], p[0], t[1], t[0], 4);
            hold(c[1], c[0], t[1], t[0], 4);
          end

    // Random toggling, including single-cycle line changes.
    for (int i = 0; i < 3000; i++)
      step(1'($urandom & 1), 1'($urandom & 1), 1'($urandom & 1), 1'($urandom & 1));
    hold(1'b1, 1'b1, 1'b0, 1'b1, 5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule